// File: doc/BRIEF.md
# Uncorrectable Error Status Logger

This block gathers uncorrectable link-level error events into a sticky 32-bit status register. Beside it sits a 32-bit mask register that software writes. Each event arrives as a one-cycle pulse on the event vector, at the bit position of its status bit. A packet header may come with it on a shared 128-bit header input.

Every event sets its status bit, whatever the mask holds. An event whose mask bit is clear is unmasked. For each unmasked event the block pulses a report request to the upstream message builder. It may also load a first-error pointer, and may copy the header into a header log.

Software reads the register values straight from the outputs. It clears status bits by writing ones to them, and writes the mask through the same narrow write port. Once the pointer has loaded, the pointer and the header log stay frozen. They stay frozen until software clears the status bit that the pointer names.

Top module: `uerr_logger`

## Requirements
- R1: The implemented status bits are 16 (unexpected completion), 15 (completer abort), 14 (completion timeout), 13 (flow-control protocol error), 12 (poisoned packet) and 4 (data-link protocol error). A pulse on `evt_i[k]` for an implemented k sets `sts_o[k]` at the next rising clock edge. All status bits reset to 0.
- R2: Status bits 31:17, 11:5, 3:1 and 0 always read 0, and event pulses at those positions have no effect on any output.
- R3: Status bits are sticky. When `wr_sts_i` is high, each 1 in `wdata_i` clears the matching status bit at the next edge, and each 0 leaves it as it is. An event in the same cycle as a clear of its bit leaves the bit set.
- R4: When `wr_msk_i` is high, mask bits 20 (unsupported request), 18 (malformed packet), 17 (receiver overflow), 16, 15 and 14 take the value of `wdata_i` at the next edge. The mask resets to 0.
- R5: Mask bits 31:21, 19 and 13:0 always read 0, and writes to them are ignored.
- R6: An event whose mask bit is 1 still sets its status bit. It raises no report, and it changes neither the pointer nor the header log. Status bits 13, 12 and 4 have no mask bit, so their events are always unmasked.
- R7: For each unmasked event on bit k, `rpt_o[k]` is high for exactly the one cycle in which `sts_o[k]` first shows that event.
- R8: The pointer `fep_o` loads the index of an unmasked event only while it is unlocked. It is locked while `sts_o[fep_o]` is 1, and it resets to 0.
- R9: When the pointer loads and the winning bit is 16, 15 or 12, `hdr_log_o` loads `hdr_i` in the same edge. Otherwise the header log keeps its value. It resets to 0.
- R10: When several unmasked events arrive in one cycle, the lowest-numbered bit wins the pointer and the header capture, and all of their status bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | One-cycle error event pulses, aligned to status bit positions |
| hdr_i | input | 128 | Header of the packet tied to this cycle's events |
| wr_sts_i | input | 1 | Write-one-to-clear strobe for the status register |
| wr_msk_i | input | 1 | Write strobe for the mask register |
| wdata_i | input | 32 | Write data for either register |
| sts_o | output | 32 | Status register value |
| msk_o | output | 32 | Mask register value |
| hdr_log_o | output | 128 | Header log value |
| fep_o | output | 5 | First-error pointer |
| rpt_o | output | 32 | Per-bit report request pulses |

## Verification
The bench drives a second error while the pointer is locked. A design that re-armed too early would move the pointer and overwrite the header. The bench clears a bit in the same cycle as a new event on it, which catches a clear that wins over the set. It fires three unmasked errors together, the lowest of which carries no header, to expose a wrong priority order and a header loaded from the wrong source. With every mask bit set, it checks that status still records the event while report, pointer and log stay still. It also pulses every reserved position, which exposes reserved bits that can be set.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned HDR_W = 128;
  localparam int unsigned PTR_W = $clog2(REG_W);

  localparam int unsigned B_UNEXP_CPL = 16;
  localparam int unsigned B_CPL_ABORT = 15;
  localparam int unsigned B_CPL_TMO   = 14;
  localparam int unsigned B_FC_PROTO  = 13;
  localparam int unsigned B_POISON    = 12;
  localparam int unsigned B_DL_PROTO  = 4;

  // status bits that hardware can set
  localparam logic [REG_W-1:0] STS_IMPL = (REG_W'(1) << B_UNEXP_CPL) | (REG_W'(1) << B_CPL_ABORT)
                                        | (REG_W'(1) << B_CPL_TMO)   | (REG_W'(1) << B_FC_PROTO)
                                        | (REG_W'(1) << B_POISON)    | (REG_W'(1) << B_DL_PROTO);
  // writable mask bits: 20, 18, 17, 16, 15, 14
  localparam logic [REG_W-1:0] MSK_IMPL = 32'h0017_C000;
  // errors whose header is logged
  localparam logic [REG_W-1:0] HDR_CAP  = (REG_W'(1) << B_UNEXP_CPL) | (REG_W'(1) << B_CPL_ABORT)
                                        | (REG_W'(1) << B_POISON);
endpackage

// File: rtl/uerr_sts_reg.sv
module uerr_sts_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (IMPL[g]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[g]) q <= 1'b1;   // set beats clear
        else if (clr_i[g]) q <= 1'b0;
      end
      assign sts_o[g] = q;
    end else begin : g_rsvd
      assign sts_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/uerr_msk_reg.sv
module uerr_msk_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] msk_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (IMPL[g]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= 1'b0;
        else if (wr_i) q <= wdata_i[g];
      end
      assign msk_o[g] = q;
    end else begin : g_rsvd
      assign msk_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/uerr_first_cap.sv
module uerr_first_cap #(
  parameter int unsigned W     = 32,
  parameter int unsigned HDR_W = 128,
  parameter logic [W-1:0] HDR_CAP = '0,
  localparam int unsigned PTR_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     cand_i,
  input  logic [W-1:0]     sts_i,
  input  logic [HDR_W-1:0] hdr_i,
  output logic [PTR_W-1:0] fep_o,
  output logic [HDR_W-1:0] hdr_log_o
);
  logic [PTR_W-1:0] fep_q;
  logic [HDR_W-1:0] hdr_q;
  logic [PTR_W-1:0] win_idx;
  logic             win_vld;
  logic             locked;
  logic             cap;

  // lowest set index wins: descending scan, last hit stays
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        win_vld = 1'b1;
        win_idx = PTR_W'(i);
      end
    end
  end

  assign locked = sts_i[fep_q];
  assign cap    = win_vld && !locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fep_q <= '0;
      hdr_q <= '0;
    end else if (cap) begin
      fep_q <= win_idx;
      if (HDR_CAP[win_idx]) hdr_q <= hdr_i;
    end
  end

  assign fep_o     = fep_q;
  assign hdr_log_o = hdr_q;
endmodule

// File: rtl/uerr_logger.sv
module uerr_logger
  import uerr_pkg::*;
#(
  parameter int unsigned HDR_BITS = HDR_W,
  parameter logic [REG_W-1:0] STS_BITS = STS_IMPL,
  parameter logic [REG_W-1:0] MSK_BITS = MSK_IMPL,
  parameter logic [REG_W-1:0] HDR_BITS_CAP = HDR_CAP
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REG_W-1:0]    evt_i,
  input  logic [HDR_BITS-1:0] hdr_i,
  input  logic                wr_sts_i,
  input  logic                wr_msk_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    sts_o,
  output logic [REG_W-1:0]    msk_o,
  output logic [HDR_BITS-1:0] hdr_log_o,
  output logic [PTR_W-1:0]    fep_o,
  output logic [REG_W-1:0]    rpt_o
);
  logic [REG_W-1:0] evt_v;
  logic [REG_W-1:0] clr_v;
  logic [REG_W-1:0] cand;
  logic [REG_W-1:0] rpt_q;

  assign evt_v = evt_i & STS_BITS;
  assign clr_v = wr_sts_i ? wdata_i : '0;
  assign cand  = evt_v & ~msk_o;

  uerr_sts_reg #(.W(REG_W), .IMPL(STS_BITS)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_v),
    .clr_i  (clr_v),
    .sts_o  (sts_o)
  );

  uerr_msk_reg #(.W(REG_W), .IMPL(MSK_BITS)) u_msk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_msk_i),
    .wdata_i (wdata_i),
    .msk_o   (msk_o)
  );

  uerr_first_cap #(.W(REG_W), .HDR_W(HDR_BITS), .HDR_CAP(HDR_BITS_CAP)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cand_i    (cand),
    .sts_i     (sts_o),
    .hdr_i     (hdr_i),
    .fep_o     (fep_o),
    .hdr_log_o (hdr_log_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rpt_q <= '0;
    else         rpt_q <= cand;
  end

  assign rpt_o = rpt_q;
endmodule

// File: rtl/uerr_logger_chk.sv
module uerr_logger_chk #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned HDR_BITS = 128,
  parameter int unsigned PTR_W = 5,
  parameter logic [REG_W-1:0] STS_BITS = '0,
  parameter logic [REG_W-1:0] MSK_BITS = '0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [REG_W-1:0]    evt_i,
  input logic                wr_sts_i,
  input logic [REG_W-1:0]    wdata_i,
  input logic [REG_W-1:0]    sts_o,
  input logic [REG_W-1:0]    msk_o,
  input logic [HDR_BITS-1:0] hdr_log_o,
  input logic [PTR_W-1:0]    fep_o,
  input logic [REG_W-1:0]    rpt_o
);
  p_rsvd_sts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o & ~STS_BITS) == '0);

  p_evt_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(evt_i) & STS_BITS) & ~sts_o) == '0));

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sts_o) & ~($past(wr_sts_i) ? $past(wdata_i) : '0)) & ~sts_o) == '0));

  p_rsvd_msk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_o & ~MSK_BITS) == '0);

  p_masked_no_rpt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rpt_o & $past(msk_o)) == '0));

  p_rpt_shows_sts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_o & ~sts_o) == '0);

  p_fep_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[fep_o] && !(wr_sts_i && wdata_i[fep_o])) |=> ($stable(fep_o) && $stable(hdr_log_o)));
endmodule

bind uerr_logger uerr_logger_chk #(
  .REG_W(REG_W), .HDR_BITS(HDR_BITS), .PTR_W(PTR_W),
  .STS_BITS(STS_BITS), .MSK_BITS(MSK_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_sts_i(wr_sts_i), .wdata_i(wdata_i),
  .sts_o(sts_o), .msk_o(msk_o), .hdr_log_o(hdr_log_o), .fep_o(fep_o), .rpt_o(rpt_o)
);

// File: tb/uerr_logger_test.sv
module uerr_logger_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] IMPL = 32'h0001_F010;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [31:0]  evt_i = '0;
  logic [127:0] hdr_i = '0;
  logic         wr_sts_i = 1'b0;
  logic         wr_msk_i = 1'b0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  sts_o, msk_o, rpt_o;
  logic [127:0] hdr_log_o;
  logic [4:0]   fep_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [127:0] HA = 128'hA5A5_0001_1111_2222_3333_4444_5555_6666;
  localparam logic [127:0] HB = 128'hB0B0_0002_7777_8888_9999_AAAA_BBBB_CCCC;
  localparam logic [127:0] HC = 128'hC3C3_0003_DDDD_EEEE_FFFF_0000_1234_5678;
  localparam logic [127:0] HD = 128'hD4D4_0004_0BAD_F00D_CAFE_BEEF_0101_0202;
  localparam logic [127:0] HE = 128'hE5E5_0005_1357_9BDF_2468_ACE0_3333_4444;
  localparam logic [127:0] HF = 128'hF6F6_0006_5555_6666_7777_8888_9999_0000;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  uerr_logger uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .hdr_i(hdr_i),
    .wr_sts_i(wr_sts_i), .wr_msk_i(wr_msk_i), .wdata_i(wdata_i),
    .sts_o(sts_o), .msk_o(msk_o), .hdr_log_o(hdr_log_o), .fep_o(fep_o), .rpt_o(rpt_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge: apply inputs for one cycle, return at the next negedge
  task automatic cyc(input logic [31:0] evt, input logic [127:0] hdr,
                     input logic ws, input logic wm, input logic [31:0] wd);
    evt_i = evt; hdr_i = hdr; wr_sts_i = ws; wr_msk_i = wm; wdata_i = wd;
    @(negedge clk_i);
    evt_i = '0; hdr_i = '0; wr_sts_i = 1'b0; wr_msk_i = 1'b0; wdata_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 sts reset", sts_o, '0);
    chk("R4 msk reset", msk_o, '0);
    chk("R8 fep reset", fep_o, '0);
    chk("R9 hdr reset", hdr_log_o, '0);
    chk("R7 rpt reset", rpt_o, '0);
  endtask

  task automatic t_first_and_lock();
    cyc(32'h0001_0000, HA, 0, 0, '0);
    chk("R1 bit16 set", sts_o, 32'h0001_0000);
    chk("R7 rpt bit16", rpt_o, 32'h0001_0000);
    chk("R8 fep first", fep_o, 5'd16);
    chk("R9 hdr first", hdr_log_o, HA);
    cyc(32'h0000_1000, HB, 0, 0, '0);
    chk("R1 bit12 set", sts_o, 32'h0001_1000);
    chk("R8 fep locked", fep_o, 5'd16);
    chk("R9 hdr locked", hdr_log_o, HA);
    chk("R7 rpt bit12", rpt_o, 32'h0000_1000);
    cyc('0, '0, 0, 0, '0);
    chk("R7 rpt one cycle", rpt_o, '0);
    cyc(32'h0000_6010, '0, 0, 0, '0);
    chk("R1 bits 14 13 4", sts_o, 32'h0001_7010);
  endtask

  task automatic t_reserved();
    cyc(~IMPL, HF, 0, 0, '0);
    chk("R2 reserved evts", sts_o, 32'h0001_7010);
    chk("R2 no rpt", rpt_o, '0);
    chk("R2 hdr untouched", hdr_log_o, HA);
  endtask

  task automatic t_w1c();
    cyc('0, '0, 1, 0, 32'h0000_0000);
    chk("R3 write zero", sts_o, 32'h0001_7010);
    cyc('0, '0, 1, 0, 32'h0000_1000);
    chk("R3 clear bit12", sts_o, 32'h0001_6010);
    cyc(32'h0000_4000, '0, 1, 0, 32'h0000_4000);
    chk("R3 set beats clear", sts_o, 32'h0001_6010);
    cyc('0, '0, 1, 0, 32'hFFFF_FFFF);
    chk("R3 clear all", sts_o, '0);
  endtask

  task automatic t_lowest();
    cyc(32'h0001_1010, HC, 0, 0, '0);
    chk("R10 all set", sts_o, 32'h0001_1010);
    chk("R10 lowest wins", fep_o, 5'd4);
    chk("R9 no hdr for bit4", hdr_log_o, HA);
    chk("R7 rpt all", rpt_o, 32'h0001_1010);
    cyc('0, '0, 1, 0, 32'h0000_0010);
    cyc(32'h0000_8000, HD, 0, 0, '0);
    chk("R8 rearm fep", fep_o, 5'd15);
    chk("R9 rearm hdr", hdr_log_o, HD);
    cyc('0, '0, 1, 0, 32'hFFFF_FFFF);
    chk("R3 clear all 2", sts_o, '0);
  endtask

  task automatic t_mask();
    cyc('0, '0, 0, 1, 32'hFFFF_FFFF);
    chk("R4 R5 mask bits", msk_o, 32'h0017_C000);
    cyc(32'h0001_0000, HE, 0, 0, '0);
    chk("R6 masked sts", sts_o, 32'h0001_0000);
    chk("R6 masked no rpt", rpt_o, '0);
    chk("R6 masked fep", fep_o, 5'd15);
    chk("R6 masked hdr", hdr_log_o, HD);
    cyc(32'h0000_1000, HF, 0, 0, '0);
    chk("R6 unmaskable rpt", rpt_o, 32'h0000_1000);
    chk("R8 fep bit12", fep_o, 5'd12);
    chk("R9 hdr bit12", hdr_log_o, HF);
    cyc('0, '0, 0, 1, 32'h0000_0000);
    chk("R4 mask cleared", msk_o, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_first_and_lock();
    t_reserved();
    t_w1c();
    t_lowest();
    t_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule